// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Serial Readout

This block holds the digital half of a 14-bit successive-approximation converter. A falling edge on the active-low start input begins a conversion. The input is first passed through a two-flop synchroniser, so the edge takes effect two clocks later. Each conversion then fills a fixed frame of 16 conversion-clock cycles. The first cycle tracks the input. The next fourteen try one bit each, most significant bit first: the controller presents a trial code to the external DAC and registers the one-bit comparator decision. The last cycle moves the finished code into a separate output shift register. The active-low busy output is low for the whole frame and rises in the cycle the new result becomes visible.

A host reads the result over a three-state serial data pin. The read enable is active low and gates both the data pin and the host's serial clock. The host's serial clock is sampled and edge-detected in the conversion clock domain. Data advances on each serial-clock falling edge, so it is stable for the following rising edge. The host sets the pace of the serial stream, and there is no back-pressure in either direction. Each fresh result overwrites the output register whether or not the host has read the last one, and the host may stop clocking at any time without loss. A mode input selects straight binary or two's complement coding. Because the output register is separate from the SAR register, a result can be read while the next conversion is running.

Top module: `sarc_top`

## Requirements
- R1: After reset, busy_n is 1, sample_en is 0, dac_code is 14'h2000, and dout is high-impedance while rd_n is 1.
- R2: A falling edge on conv_start_n starts a conversion when busy_n is high. Busy_n goes low two to three clocks later.
- R3: Once a conversion has started, further falling edges on conv_start_n have no effect until it ends. No second conversion follows the first.
- R4: busy_n stays low for exactly 16 clock cycles per conversion.
- R5: In the first cycle of a conversion, sample_en is 1 and dac_code is 14'h2000 (mid-scale). In the second cycle sample_en is 0 and dac_code is still 14'h2000. In the third cycle dac_code is {cmp of bit 13, 1, 12'b0}.
- R6: The comparator is 1 when the analog input is at or above dac_code. The converted code is then the largest code not above the input.
- R7: With bipolar at 0 the result is straight binary. With bipolar at 1 the result's MSB (bit 13) is inverted, giving two's complement.
- R8: With rd_n at 0, dout shows the result MSB first. Each falling serial-clock edge advances one bit. After the 14th bit, further falling edges leave dout at bit 0.
- R9: With rd_n at 1, dout is high-impedance and serial-clock edges do not advance the output register.
- R10: The output register changes only by shifting or at the end of a conversion. A result can be read while the next conversion runs, and it is replaced when busy_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Start request, falling edge begins a conversion |
| cmp_in | input | 1 | Comparator decision, 1 when input >= dac_code |
| bipolar | input | 1 | 0: straight binary, 1: two's complement |
| rd_n | input | 1 | Active-low read enable for dout and sclk |
| sclk | input | 1 | Host serial clock |
| dac_code | output | 14 | Trial code for the DAC |
| sample_en | output | 1 | High in the tracking cycle of a conversion |
| busy_n | output | 1 | Low while a conversion is in progress |
| dout | output | 1 | Three-state serial data, MSB first |

## Verification
The hardest cases to reach from the ports are the ones where two activities overlap. One is a second start edge that arrives mid-frame. The other is a partly read result that must survive a conversion still running. The bench drives a new falling edge on conv_start_n while busy_n is already low, then checks that the frame is still 16 cycles and that no further frame follows. It also shifts one bit out, starts a new conversion with a different input, and watches dout hold the old bit until busy_n rises, when the new MSB must appear.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int SARC_RES_BITS    = 14;
  localparam int SARC_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_TRIAL,
    ST_XFER
  } conv_state_t;
endpackage

// File: rtl/sarc_sync_edge.sv
module sarc_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= RST_VAL;
    else        last <= chain[STAGES-1];
  end

  assign rise = ~last &  chain[STAGES-1];
  assign fall =  last & ~chain[STAGES-1];
endmodule

// File: rtl/sarc_engine.sv
module sarc_engine
  import sarc_pkg::*;
#(
  parameter int W = SARC_RES_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_fall,
  input  logic         cmp_in,
  output logic [W-1:0] dac_code,
  output logic         sample_en,
  output logic         busy_n,
  output logic         eoc,
  output logic [W-1:0] result
);
  localparam int          BIDX_W = $clog2(W);
  localparam logic [W-1:0] MID   = {1'b1, {(W-1){1'b0}}};

  conv_state_t       state;
  logic [W-1:0]      sar;
  logic [BIDX_W-1:0] bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sar   <= MID;
      bidx  <= BIDX_W'(W-1);
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_fall) begin
            state <= ST_SAMPLE;
            sar   <= MID;
            bidx  <= BIDX_W'(W-1);
          end
        end
        ST_SAMPLE: state <= ST_TRIAL;
        ST_TRIAL: begin
          sar[bidx] <= cmp_in;
          if (bidx != '0) begin
            sar[bidx - 1'b1] <= 1'b1;
            bidx             <= bidx - 1'b1;
          end else begin
            state <= ST_XFER;
          end
        end
        ST_XFER: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dac_code  = sar;
  assign result    = sar;
  assign sample_en = (state == ST_SAMPLE);
  assign busy_n    = (state == ST_IDLE);
  assign eoc       = (state == ST_XFER);

  // R4: the transfer cycle always closes the frame
  a_r4_xfer_ends: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_XFER |=> state == ST_IDLE);

  // R3: trials keep counting down whatever the start input does
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIAL && bidx != '0) |=>
      (state == ST_TRIAL && bidx == $past(bidx) - 1'b1));

  // R5: tracking cycle presents mid-scale
  a_r5_mid_trial: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SAMPLE |-> dac_code == MID);

  // R6: each trial keeps the comparator decision
  a_r6_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_TRIAL |=> sar[$past(bidx)] == $past(cmp_in));
endmodule

// File: rtl/sarc_shifter.sv
module sarc_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] result,
  input  logic         bipolar,
  input  logic         rd_n,
  input  logic         sclk_fall,
  output logic         dout
);
  logic [W-1:0] shreg;
  logic [W-1:0] coded;
  logic         step;

  always_comb begin
    coded = result;
    if (bipolar) coded[W-1] = ~result[W-1];
  end

  assign step = sclk_fall & ~rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= coded;
    else if (step) shreg <= {shreg[W-2:0], shreg[0]};
  end

  assign dout = rd_n ? 1'bz : shreg[W-1];

  // R10: contents stay put without a shift or a load
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(shreg));

  // R8: a shift moves every bit one place toward the MSB
  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> shreg[W-1:1] == $past(shreg[W-2:0]));

  // R7: low bits load unchanged in either coding
  a_r7_code_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shreg[W-2:0] == $past(result[W-2:0]));

  // R9: with read disabled, clock edges leave the register alone
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && !load) |=> $stable(shreg));
endmodule

// File: rtl/sarc_top.sv
module sarc_top
  import sarc_pkg::*;
#(
  parameter int W      = SARC_RES_BITS,
  parameter int STAGES = SARC_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start_n,
  input  logic         cmp_in,
  input  logic         bipolar,
  input  logic         rd_n,
  input  logic         sclk,
  output logic [W-1:0] dac_code,
  output logic         sample_en,
  output logic         busy_n,
  output logic         dout
);
  logic start_fall, start_rise_unused;
  logic sclk_fall, sclk_rise_unused;
  logic eoc;
  logic [W-1:0] result;

  sarc_sync_edge #(.STAGES(STAGES), .RST_VAL(1'b1)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .d(conv_start_n),
    .rise(start_rise_unused), .fall(start_fall)
  );

  sarc_sync_edge #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk),
    .rise(sclk_rise_unused), .fall(sclk_fall)
  );

  sarc_engine #(.W(W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_en(sample_en), .busy_n(busy_n),
    .eoc(eoc), .result(result)
  );

  sarc_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(eoc), .result(result),
    .bipolar(bipolar), .rd_n(rd_n), .sclk_fall(sclk_fall), .dout(dout)
  );
endmodule

// File: tb/sarc_top_tb.sv
module sarc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start_n = 1'b1;
  logic        cmp_in;
  logic        bipolar = 1'b0;
  logic        rd_n = 1'b1;
  logic        sclk = 1'b0;
  logic [13:0] dac_code;
  logic        sample_en;
  logic        busy_n;
  wire         dout;
  logic [13:0] vin = '0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  // comparator model (R6): 1 when input at or above the trial code
  assign cmp_in = (vin >= dac_code);

  sarc_top u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .cmp_in(cmp_in),
    .bipolar(bipolar), .rd_n(rd_n), .sclk(sclk), .dac_code(dac_code),
    .sample_en(sample_en), .busy_n(busy_n), .dout(dout)
  );

  function automatic logic [13:0] exp_code(logic [13:0] v, logic bip);
    return bip ? (v ^ 14'h2000) : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(logic [13:0] v, logic bip, bit retrig);
    int n = 0;
    int w = 0;
    vin = v;
    bipolar = bip;
    @(negedge clk);
    conv_start_n = 1'b0;
    while (busy_n && w < 10) begin
      @(negedge clk);
      w++;
    end
    chk(w >= 2 && w <= 3, "R2 start latency", w, 2);
    while (!busy_n && n < 100) begin
      if (n == 0) begin
        chk(sample_en == 1'b1, "R5 sample_en", int'(sample_en), 1);
        chk(dac_code == 14'h2000, "R5 first trial", int'(dac_code), 'h2000);
      end
      if (n == 1) begin
        chk(sample_en == 1'b0, "R5 sample_en off", int'(sample_en), 0);
        conv_start_n = 1'b1;
      end
      if (n == 2)
        chk(dac_code == ((v & 14'h2000) | 14'h1000), "R5 second trial",
            int'(dac_code), int'((v & 14'h2000) | 14'h1000));
      if (retrig && n == 5) conv_start_n = 1'b0;
      if (retrig && n == 8) conv_start_n = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(n == 16, "R4 busy length", n, 16);
    if (retrig) begin
      repeat (8) @(negedge clk);
      chk(busy_n == 1'b1, "R3 retrigger ignored", int'(busy_n), 1);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(logic [13:0] e, string req);
    int bad = 0;
    rd_n = 1'b0;
    @(negedge clk);
    for (int i = 13; i >= 0; i--) begin
      if (dout !== e[i]) bad++;
      sclk_pulse();
    end
    chk(bad == 0, req, bad, 0);
    sclk_pulse();
    chk(dout === e[0], "R8 holds last bit", int'(dout), int'(e[0]));
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] v;
    logic [13:0] a;
    logic [13:0] b;
    logic        bp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_n == 1'b1, "R1 busy_n", int'(busy_n), 1);
    chk(sample_en == 1'b0, "R1 sample_en", int'(sample_en), 0);
    chk(dac_code == 14'h2000, "R1 dac_code", int'(dac_code), 'h2000);
    chk(dout === 1'bz, "R1 dout z", int'(dout), 0);

    // directed corner codes, R6 and R7
    convert(14'h0000, 1'b0, 0); read_word(exp_code(14'h0000, 0), "R6 zero");
    convert(14'h3FFF, 1'b0, 0); read_word(exp_code(14'h3FFF, 0), "R6 full");
    convert(14'h2000, 1'b1, 0); read_word(exp_code(14'h2000, 1), "R7 mid twos");
    convert(14'h1FFF, 1'b1, 0); read_word(exp_code(14'h1FFF, 1), "R7 below mid twos");

    // R3: a second start edge mid-frame
    convert(14'h0ABC, 1'b0, 1); read_word(exp_code(14'h0ABC, 0), "R3 result kept");

    // R9: read disabled, sclk edges have no effect
    convert(14'h2D5A, 1'b0, 0);
    chk(dout === 1'bz, "R9 dout z", int'(dout), 0);
    repeat (3) sclk_pulse();
    read_word(exp_code(14'h2D5A, 0), "R9 no shift while disabled");

    // R10: partly read result survives the next conversion
    a = 14'h1234;
    b = 14'h3C0F;
    convert(a, 1'b0, 0);
    rd_n = 1'b0;
    @(negedge clk);
    sclk_pulse();
    vin = b;
    conv_start_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_start_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(busy_n == 1'b0, "R10 conversion running", int'(busy_n), 0);
    chk(dout === a[12], "R10 old bit held", int'(dout), int'(a[12]));
    while (!busy_n) @(negedge clk);
    chk(dout === b[13], "R10 new MSB", int'(dout), int'(b[13]));
    rd_n = 1'b1;
    read_word(exp_code(b, 0), "R10 new word");

    // random inputs and coding
    for (int k = 0; k < 8; k++) begin
      v  = 14'($urandom);
      bp = 1'($urandom);
      convert(v, bp, 0);
      read_word(exp_code(v, bp), "R6 R7 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule